// File: doc/BRIEF.md
# Register-Mapped Serial Port Controller

This block is a compact asynchronous serial port that software drives through a small register window. Software writes characters into a transmit queue, and a serializer shifts them out one at a time as start, data and stop bits. Characters that a separate oversampling receiver has recovered arrive on a strobe-and-byte input. They wait in a receive queue until software reads them. Both queues hold eight characters. Frames use one start bit and one stop bit, carry no parity, and hold either seven or eight data bits.

A master enable must be set before any of the port's own registers respond. Beyond that, software can set an interrupt mask and identify the interrupt cause, choose the character width, pause the line with a break, drive the request-to-send output by hand or let the receive fill level drive it, hold transmission while clear-to-send is inactive, flush either queue, and read both fill levels from one packed status word. A 16-bit divider value sets the bit rate. One bit lasts 8 × (divider + 1) clock cycles, and a divider value of zero is a legal setting.

The receiver hook consists of an oversampling tick (one eighth of a bit), a receiver-enable output and the selected character width. An external receiver uses these to time and frame its samples.

Top module: `ser_port_ctrl`

## Requirements
- R1: After reset, the serial line is high, request-to-send is inactive (`rts_n_o`=1), `irq_o`=0, the master enable reads 0, the divider reads 0, and the extra-control register reads 0x03 (both directions enabled).
- R2: While master-enable bit 0 (offset 0x04) is clear, reads from offsets 0x40 to 0x68 return 0 and writes to those offsets are ignored.
- R3: With the block enabled, the scratch register (0x5C) reads back the last byte written to it.
- R4: With line-control (0x4C) bit 0 set, a byte written to the data register (0x40) is sent as a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts 8 × (divider + 1) clocks, where the divider is at offset 0x68.
- R5: With line-control bit 0 clear, only data bits 0 to 6 are sent, and the stop bit follows bit 6. Received bytes are stored with bit 7 cleared.
- R6: Each queue holds 8 characters, and a write to a full transmit queue is dropped. The status word (0x64) reports the transmit fill level in bits [27:24] and the receive fill level in bits [19:16]. Line status (0x54) bit 5 is 0 while the transmit queue is full.
- R7: Receiver strobes push bytes that reads of 0x40 return in arrival order. A strobe into a full queue with no read in the same cycle is dropped and sets line-status bit 1, which clears when line status is read. A read and a strobe in the same cycle on a full queue leave the level at 8 and set no overrun.
- R8: While line-control bit 7 is set, offsets 0x40 and 0x44 read and write the low and high bytes of the divider, and the queues are untouched.
- R9: Writing the identify register (0x48) with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. A receive strobe in the same cycle as a receive flush is discarded.
- R10: Interrupt-enable (0x44) bit 0 enables the receive-data cause and bit 1 the transmit-empty cause. `irq_o` and bit 0 of offset 0x00 show the OR of the enabled causes. The identify register reads 0xC4 for receive data (this cause has priority), 0xC2 for transmit empty, and 0xC1 when nothing is pending.
- R11: Modem-control (0x50) bit 1 set drives `rts_n_o` low. Modem-status (0x58) bit 4 reads the inverse of `cts_n_i`. With extra-control bit 2 set, `rts_n_o` is high when the receive level is at least 4 + extra-control[5:4], and low otherwise.
- R12: With extra-control bit 3 set, no new frame starts while `cts_n_i` is high, and a queued character stays queued.
- R13: Line-control bit 6 holds the serial line low for as long as it is set.
- R14: With extra-control bit 0 clear, receive strobes are ignored and `rx_enable_o` is 0. With bit 1 clear, no frame is sent and the transmit queue keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read data is combinational) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| rx_strobe_i | input | 1 | External receiver has a byte |
| rx_byte_i | input | 8 | Byte from the external receiver |
| rx_enable_o | output | 1 | Receiver may deliver bytes |
| rx_eight_o | output | 1 | Selected width is eight bits |
| os_tick_o | output | 1 | One-eighth-bit timing tick |
| txd_o | output | 1 | Serial transmit line |
| rts_n_o | output | 1 | Request-to-send, active low |
| cts_n_i | input | 1 | Clear-to-send, active low |
| irq_o | output | 1 | Interrupt request |

## Verification
The receive queue has two actors in a single cycle: the external receiver pushing a character and software popping one through the data register. The bench fills the queue to eight entries. It then raises a read of 0x40 and a receive strobe at the same clock edge. It expects the oldest byte to be returned, the level to stay at 8 and no overrun to be flagged, and the new byte to come out last when the queue is drained. A second collision puts a receive flush and a strobe in the same cycle, and the bench expects an empty queue afterwards.

// File: rtl/serp_pkg.sv
package serp_pkg;

    localparam int FIFO_DEPTH = 8;
    localparam int DATA_W     = 8;
    localparam int DIV_W      = 16;
    localparam int ADDR_W     = 7;

    typedef enum logic [ADDR_W-1:0] {
        OFF_IRQ  = 7'h00,
        OFF_ENB  = 7'h04,
        OFF_DATA = 7'h40,
        OFF_IER  = 7'h44,
        OFF_IIR  = 7'h48,
        OFF_LCR  = 7'h4C,
        OFF_MCR  = 7'h50,
        OFF_LSR  = 7'h54,
        OFF_MSR  = 7'h58,
        OFF_SCR  = 7'h5C,
        OFF_CNTL = 7'h60,
        OFF_STAT = 7'h64,
        OFF_BAUD = 7'h68
    } reg_off_e;

    // line control: bit7 divider access, bit6 break, bit0 eight-bit width
    typedef struct packed {
        logic       div_access;
        logic       brk;
        logic [4:0] spare;
        logic       eight;
    } line_ctl_t;

    // extra control: [5:4] rts level code, 3 auto cts, 2 auto rts, 1 tx, 0 rx
    typedef struct packed {
        logic [1:0] rts_lvl;
        logic       auto_cts;
        logic       auto_rts;
        logic       tx_en;
        logic       rx_en;
    } xctl_t;

    function automatic logic [3:0] rts_threshold(input logic [1:0] code);
        return 4'd4 + {2'b00, code};
    endfunction

endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic [W-1:0]                 din_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 dout_o,
    output logic                         full_o,
    output logic                         empty_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic [LW-1:0] count;
    logic          do_push, do_pop;

    assign full_o  = (count == LW'(DEPTH));
    assign empty_o = (count == '0);
    assign level_o = count;
    assign dout_o  = mem[rptr];
    assign do_pop  = pop_i && !empty_o;
    assign do_push = push_i && (!full_o || pop_i);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i || flush_i) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din_i;
                wptr      <= bump(wptr);
            end
            if (do_pop) rptr <= bump(rptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    a_r6_level_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        count <= LW'(DEPTH));

    a_r6_full_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o);

endmodule

// File: rtl/ser_baud.sv
module ser_baud #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt;

    // ">=" keeps a lowered divider from waiting for a full wrap
    assign tick_o = (cnt >= div_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || tick_o) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          go_i,
    input  logic          eight_i,
    input  logic          brk_i,
    input  logic [DW-1:0] data_i,
    output logic          pop_o,
    output logic          busy_o,
    output logic          txd_o
);
    localparam int CW = $clog2(DW + 3);

    logic [DW+1:0] shreg;
    logic [CW-1:0] left;
    logic [2:0]    sub;

    assign pop_o = go_i && !busy_o;
    assign txd_o = brk_i ? 1'b0 : (busy_o ? shreg[0] : 1'b1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_o <= 1'b0;
            shreg  <= '1;
            left   <= '0;
            sub    <= '0;
        end else if (pop_o) begin
            busy_o <= 1'b1;
            sub    <= '0;
            shreg  <= eight_i ? {1'b1, data_i, 1'b0}
                              : {2'b11, data_i[DW-2:0], 1'b0};
            left   <= eight_i ? CW'(DW + 1) : CW'(DW);
        end else if (busy_o && tick_i) begin
            sub <= sub + 1'b1;
            if (sub == 3'd7) begin
                if (left == '0) begin
                    busy_o <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[DW+1:1]};
                    left  <= left - 1'b1;
                end
            end
        end
    end

    a_r4_frame_starts_low: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_o && !brk_i) |=> (!txd_o || brk_i));

endmodule

// File: rtl/ser_port_ctrl.sv
module ser_port_ctrl
    import serp_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DIV_W-1:0]  reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              rx_strobe_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic              rx_enable_o,
    output logic              rx_eight_o,
    output logic              os_tick_o,
    output logic              txd_o,
    output logic              rts_n_o,
    input  logic              cts_n_i,
    output logic              irq_o
);
    localparam int LW = $clog2(DEPTH + 1);

    logic              enb, mcr_rts, ovr;
    logic [1:0]        ier;
    line_ctl_t         lcr;
    xctl_t             xctl;
    logic [DATA_W-1:0] scratch;
    logic [DIV_W-1:0]  divider;
    reg_off_e          off;
    logic              is_port, wr_ok, rd_ok;

    logic              tx_push, tx_pop, tx_flush, tx_full, tx_empty, tx_busy, tx_go;
    logic              rx_push, rx_pop, rx_flush, rx_full, rx_empty;
    logic [DATA_W-1:0] tx_dout, rx_dout, rx_din;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic              tick, rx_cause, tx_cause, irq_pend;
    logic [1:0]        iid;

    assign off     = reg_off_e'(reg_addr_i);
    assign is_port = (reg_addr_i >= 7'h40);
    assign wr_ok   = reg_wr_i && (enb || !is_port);
    assign rd_ok   = reg_rd_i && enb;

    // queue control
    assign tx_push  = wr_ok && off == OFF_DATA && !lcr.div_access;
    assign rx_pop   = rd_ok && off == OFF_DATA && !lcr.div_access;
    assign rx_flush = wr_ok && off == OFF_IIR && reg_wdata_i[1];
    assign tx_flush = wr_ok && off == OFF_IIR && reg_wdata_i[2];
    assign rx_push  = rx_strobe_i && enb && xctl.rx_en;
    assign rx_din   = lcr.eight ? rx_byte_i : {1'b0, rx_byte_i[DATA_W-2:0]};
    assign tx_go    = enb && xctl.tx_en && !tx_empty && (!xctl.auto_cts || !cts_n_i);

    ser_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk_i, .rst_i, .flush_i(tx_flush), .push_i(tx_push),
        .din_i(reg_wdata_i[DATA_W-1:0]), .pop_i(tx_pop), .dout_o(tx_dout),
        .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_lvl));

    ser_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk_i, .rst_i, .flush_i(rx_flush), .push_i(rx_push),
        .din_i(rx_din), .pop_i(rx_pop), .dout_o(rx_dout),
        .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_lvl));

    ser_baud #(.W(DIV_W)) u_baud (
        .clk_i, .rst_i, .div_i(divider), .tick_o(tick));

    ser_tx #(.DW(DATA_W)) u_tx (
        .clk_i, .rst_i, .tick_i(tick), .go_i(tx_go), .eight_i(lcr.eight),
        .brk_i(lcr.brk), .data_i(tx_dout), .pop_o(tx_pop), .busy_o(tx_busy),
        .txd_o(txd_o));

    // register writes
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            enb     <= 1'b0;
            ier     <= '0;
            lcr     <= '0;
            mcr_rts <= 1'b0;
            scratch <= '0;
            xctl    <= 6'b00_0011;
            divider <= '0;
        end else if (wr_ok) begin
            case (off)
                OFF_ENB:  enb <= reg_wdata_i[0];
                OFF_DATA: if (lcr.div_access) divider[7:0] <= reg_wdata_i[7:0];
                OFF_IER:  if (lcr.div_access) divider[15:8] <= reg_wdata_i[7:0];
                          else ier <= reg_wdata_i[1:0];
                OFF_LCR:  lcr     <= line_ctl_t'(reg_wdata_i[7:0]);
                OFF_MCR:  mcr_rts <= reg_wdata_i[1];
                OFF_SCR:  scratch <= reg_wdata_i[7:0];
                OFF_CNTL: xctl    <= xctl_t'(reg_wdata_i[5:0]);
                OFF_BAUD: divider <= reg_wdata_i;
                default: ;
            endcase
        end
    end

    // overrun: set wins over the clearing read
    always_ff @(posedge clk_i) begin
        if (rst_i)                                      ovr <= 1'b0;
        else if (rx_push && rx_full && !rx_pop && !rx_flush) ovr <= 1'b1;
        else if (rd_ok && off == OFF_LSR)               ovr <= 1'b0;
    end

    // interrupt causes, receive first
    assign rx_cause = ier[0] && !rx_empty;
    assign tx_cause = ier[1] && tx_empty;
    assign irq_pend = enb && (rx_cause || tx_cause);
    assign iid      = rx_cause ? 2'b10 : (tx_cause ? 2'b01 : 2'b00);
    assign irq_o    = irq_pend;

    assign rts_n_o     = !(xctl.auto_rts ? (4'(rx_lvl) < rts_threshold(xctl.rts_lvl)) : mcr_rts);
    assign rx_enable_o = enb && xctl.rx_en;
    assign rx_eight_o  = lcr.eight;
    assign os_tick_o   = tick;

    always_comb begin
        reg_rdata_o = '0;
        if (enb || !is_port) begin
            case (off)
                OFF_IRQ:  reg_rdata_o[0]     = irq_pend;
                OFF_ENB:  reg_rdata_o[0]     = enb;
                OFF_DATA: reg_rdata_o[7:0]   = lcr.div_access ? divider[7:0] : rx_dout;
                OFF_IER:  reg_rdata_o[7:0]   = lcr.div_access ? divider[15:8] : {6'b0, ier};
                OFF_IIR:  reg_rdata_o[7:0]   = {2'b11, 3'b000, iid, !irq_pend};
                OFF_LCR:  reg_rdata_o[7:0]   = lcr;
                OFF_MCR:  reg_rdata_o[1]     = mcr_rts;
                OFF_LSR:  reg_rdata_o[7:0]   = {1'b0, tx_empty && !tx_busy, !tx_full,
                                                3'b000, ovr, !rx_empty};
                OFF_MSR:  reg_rdata_o[4]     = !cts_n_i;
                OFF_SCR:  reg_rdata_o[7:0]   = scratch;
                OFF_CNTL: reg_rdata_o[5:0]   = xctl;
                OFF_STAT: begin
                    reg_rdata_o[27:24] = 4'(tx_lvl);
                    reg_rdata_o[19:16] = 4'(rx_lvl);
                end
                OFF_BAUD: reg_rdata_o[15:0]  = divider;
                default: ;
            endcase
        end
    end

    a_r2_gated_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enb && reg_rd_i && reg_addr_i >= 7'h40) |-> (reg_rdata_o == '0));

    a_r12_cts_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (xctl.auto_cts && cts_n_i && !tx_busy) |=> !tx_busy);

    a_r13_break_low: assert property (@(posedge clk_i) disable iff (rst_i)
        lcr.brk |-> !txd_o);

    a_r7_overrun_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        (rx_push && rx_full && !rx_pop && !rx_flush) |=> ovr);

endmodule

// File: tb/ser_port_ctrl_bench.sv
module ser_port_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_stb = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_en_o, rx_eight_o, os_tick, txd, rts_n, irq;
    logic        cts_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_port_ctrl u_ser_port_ctrl (
        .clk_i(clk), .rst_i(rst), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_strobe_i(rx_stb),
        .rx_byte_i(rx_byte), .rx_enable_o(rx_en_o), .rx_eight_o(rx_eight_o),
        .os_tick_o(os_tick), .txd_o(txd), .rts_n_o(rts_n), .cts_n_i(cts_n),
        .irq_o(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk); rx_stb = 1'b1; rx_byte = b;
        @(negedge clk); rx_stb = 1'b0;
    endtask

    function automatic logic [3:0] rx_lvl(input logic [31:0] s); return s[19:16]; endfunction
    function automatic logic [3:0] tx_lvl(input logic [31:0] s); return s[27:24]; endfunction

    task automatic tx_capture(input int b, input bit eight, output logic [7:0] val, output logic stop);
        int n, per, waited, t, t_prev;
        n = eight ? 8 : 7;
        per = 8 * (b + 1);
        waited = 0; t_prev = 0; val = '0; stop = 1'b0;
        do begin @(negedge clk); waited++; end while (txd === 1'b1 && waited < 4000);
        if (waited >= 4000) return;
        for (int i = 1; i <= n + 1; i++) begin
            t = i * per + per / 2 - b / 2;
            repeat (t - t_prev) @(negedge clk);
            t_prev = t;
            if (i <= n) val[i-1] = txd; else stop = txd;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 txd idle", txd, 1);
        check("R1 rts_n", rts_n, 1);
        check("R1 irq", irq, 0);
        bus_rd(7'h04, d); check("R1 enable reg", d, 0);
        bus_wr(7'h04, 16'h1);
        bus_rd(7'h68, d); check("R1 divider", d, 0);
        bus_rd(7'h60, d); check("R1 extra control", d, 32'h3);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        bus_wr(7'h04, 16'h0);
        bus_wr(7'h5C, 16'h5A);
        bus_rd(7'h5C, d); check("R2 read while disabled", d, 0);
        bus_rd(7'h60, d); check("R2 cntl read while disabled", d, 0);
        bus_wr(7'h04, 16'h1);
        bus_rd(7'h5C, d); check("R2 write while disabled ignored", d, 0);
        bus_wr(7'h5C, 16'hA5);
        bus_rd(7'h5C, d); check("R3 scratch readback", d, 32'hA5);
    endtask

    task automatic t_tx8;
        logic [7:0] v; logic s;
        bus_wr(7'h4C, 16'h01);
        bus_wr(7'h40, 16'hA6);
        tx_capture(0, 1, v, s);
        check("R4 8-bit data div0", v, 8'hA6); check("R4 stop div0", s, 1);
        bus_wr(7'h68, 16'd2);
        bus_wr(7'h40, 16'h3C);
        tx_capture(2, 1, v, s);
        check("R4 8-bit data div2", v, 8'h3C); check("R4 stop div2", s, 1);
        bus_wr(7'h68, 16'd0);
    endtask

    task automatic t_tx7;
        logic [7:0] v; logic s; logic [31:0] d;
        bus_wr(7'h4C, 16'h00);
        bus_wr(7'h40, 16'h45);
        tx_capture(0, 0, v, s);
        check("R5 7-bit data", v, 8'h45); check("R5 stop after bit 6", s, 1);
        rx_push(8'hFF);
        bus_rd(7'h40, d); check("R5 rx bit7 cleared", d, 32'h7F);
    endtask

    task automatic t_fifo;
        logic [31:0] d;
        bus_wr(7'h60, 16'h01);
        for (int i = 0; i < 9; i++) bus_wr(7'h40, 16'(i));
        bus_rd(7'h64, d); check("R6 tx level capped at 8", tx_lvl(d), 8);
        bus_rd(7'h54, d); check("R6 lsr no space", d[5], 0);
        repeat (40) @(negedge clk);
        check("R14 tx disabled line idle", txd, 1);
        bus_rd(7'h64, d); check("R14 tx queue kept", tx_lvl(d), 8);
        bus_wr(7'h48, 16'h4);
        bus_rd(7'h64, d); check("R9 tx flush", tx_lvl(d), 0);
        bus_wr(7'h60, 16'h03);
    endtask

    task automatic t_rx;
        logic [31:0] d;
        bus_wr(7'h4C, 16'h01);
        for (int i = 0; i < 8; i++) rx_push(8'h10 + 8'(i));
        bus_rd(7'h64, d); check("R6 rx level 8", rx_lvl(d), 8);
        rx_push(8'hEE);
        bus_rd(7'h54, d); check("R7 overrun set", d[1], 1);
        bus_rd(7'h54, d); check("R7 overrun cleared by read", d[1], 0);
        @(negedge clk); addr = 7'h40; rd = 1'b1; rx_stb = 1'b1; rx_byte = 8'h99;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0; rx_stb = 1'b0;
        check("R7 concurrent pop value", d, 32'h10);
        bus_rd(7'h64, d); check("R7 concurrent level", rx_lvl(d), 8);
        bus_rd(7'h54, d); check("R7 concurrent no overrun", d[1], 0);
        for (int i = 1; i < 8; i++) begin
            bus_rd(7'h40, d); check("R7 rx order", d, 32'h10 + i);
        end
        bus_rd(7'h40, d); check("R7 concurrent byte last", d, 32'h99);
        bus_rd(7'h64, d); check("R7 drained", rx_lvl(d), 0);
    endtask

    task automatic t_dlab;
        logic [31:0] d;
        bus_wr(7'h44, 16'h0);
        bus_wr(7'h4C, 16'h81);
        bus_wr(7'h40, 16'h34);
        bus_wr(7'h44, 16'h12);
        bus_rd(7'h68, d); check("R8 divider via access window", d, 32'h1234);
        bus_rd(7'h40, d); check("R8 low byte read", d, 32'h34);
        bus_rd(7'h64, d); check("R8 queues untouched", d, 0);
        bus_wr(7'h4C, 16'h01);
        bus_rd(7'h44, d); check("R8 ier unchanged", d, 0);
        bus_wr(7'h68, 16'h0);
    endtask

    task automatic t_flush;
        logic [31:0] d;
        rx_push(8'h01); rx_push(8'h02);
        @(negedge clk); addr = 7'h48; wdata = 16'h2; wr = 1'b1; rx_stb = 1'b1; rx_byte = 8'h55;
        @(negedge clk); wr = 1'b0; rx_stb = 1'b0;
        bus_rd(7'h64, d); check("R9 rx flush beats strobe", rx_lvl(d), 0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        bus_wr(7'h44, 16'h3);
        bus_rd(7'h48, d); check("R10 tx-empty id", d, 32'hC2);
        check("R10 irq tx", irq, 1);
        bus_rd(7'h00, d); check("R10 irq status", d, 1);
        rx_push(8'h42);
        bus_rd(7'h48, d); check("R10 rx priority id", d, 32'hC4);
        bus_wr(7'h44, 16'h0);
        bus_rd(7'h48, d); check("R10 none pending id", d, 32'hC1);
        check("R10 irq masked", irq, 0);
        bus_wr(7'h44, 16'h1);
        check("R10 rx cause alone", irq, 1);
        bus_wr(7'h44, 16'h0);
        bus_wr(7'h48, 16'h2);
    endtask

    task automatic t_rts;
        logic [31:0] d;
        bus_wr(7'h50, 16'h2); check("R11 manual rts on", rts_n, 0);
        bus_wr(7'h50, 16'h0); check("R11 manual rts off", rts_n, 1);
        cts_n = 1'b0;
        bus_rd(7'h58, d); check("R11 cts low visible", d, 32'h10);
        cts_n = 1'b1;
        bus_rd(7'h58, d); check("R11 cts high visible", d, 0);
        bus_wr(7'h60, 16'h07);
        for (int i = 0; i < 3; i++) rx_push(8'(i));
        check("R11 auto rts below 4", rts_n, 0);
        rx_push(8'h03);
        check("R11 auto rts at 4", rts_n, 1);
        bus_wr(7'h60, 16'h17);
        check("R11 auto rts level 5", rts_n, 0);
        bus_wr(7'h48, 16'h2);
        bus_wr(7'h60, 16'h03);
    endtask

    task automatic t_cts;
        logic [31:0] d; logic [7:0] v; logic s;
        cts_n = 1'b1;
        bus_wr(7'h60, 16'h0B);
        bus_wr(7'h40, 16'h5D);
        repeat (50) @(negedge clk);
        check("R12 held while cts high", txd, 1);
        bus_rd(7'h64, d); check("R12 char stays queued", tx_lvl(d), 1);
        cts_n = 1'b0;
        tx_capture(0, 1, v, s);
        check("R12 sent after cts", v, 8'h5D);
        bus_wr(7'h60, 16'h03);
    endtask

    task automatic t_brk;
        bus_wr(7'h4C, 16'h41);
        repeat (3) @(negedge clk);
        check("R13 break low", txd, 0);
        bus_wr(7'h4C, 16'h01);
        check("R13 break released", txd, 1);
    endtask

    task automatic t_rx_off;
        logic [31:0] d;
        bus_wr(7'h60, 16'h02);
        check("R14 rx_enable_o low", rx_en_o, 0);
        rx_push(8'h77);
        bus_rd(7'h64, d); check("R14 rx strobe ignored", rx_lvl(d), 0);
        bus_wr(7'h60, 16'h03);
        check("R14 rx_enable_o high", rx_en_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset; t_gate; t_tx8; t_tx7; t_fifo; t_rx; t_dlab;
        t_flush; t_irq; t_rts; t_cts; t_brk; t_rx_off;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule